// File: doc/BRIEF.md
# Two-Wire Debug Link Frame Master

This block is the line-level engine of a two-wire serial debug link. One output drives the link clock; the data line is bidirectional, split into an output value, an output enable and a sampled input. A host issues one request at a time over a valid/ready handshake, and the block turns it into a complete frame of clock strobes. It can select a target register (address write), read back the address/status register, write one data byte, read one data byte, or reset the target by holding the clock low for a long time.

Each frame is built field by field: a start strobe, a 2-bit instruction, a 2-bit length (data frames only), eight address or data bits sent or sampled least significant bit first, an optional target-paced wait phase, and a stop strobe. Because a long low clock is the target's reset signal, every ordinary strobe has a short, fixed low phase. All widths are parameters in clock cycles, so one netlist serves any system clock. Multi-byte sequences and status decoding belong to the host.

Top module: `dbg2w_master`

## Requirements
- R1: After reset, and whenever busy is low, the link clock is high, the data output enable is low and req_ready is high.
- R2: A request is taken only on a cycle where req_valid and req_ready are both high; busy is high from the cycle after acceptance until the cycle that rsp_done or rsp_err pulses, and req_valid held while busy starts no new frame.
- R3: Every frame begins with a start strobe and ends with a stop strobe, both with the data output enable low, and carries exactly the strobes its fields call for.
- R4: Opcodes on req_op are 0 address write, 1 address read, 2 data write, 3 data read, 4 target reset. The instruction goes out on the two strobes after start, first bit then second: address write 1,1; address read 0,1; data write 1,0; data read 0,0.
- R5: Data write and data read frames drive two zero bits (length of one byte) right after the instruction.
- R6: Address write and data write send req_data least significant bit first, one bit per strobe, with the output enable high.
- R7: Address read and data read release the line for eight strobes, sample the line once after each, and present the sampled byte on rsp_data with the first sampled bit as bit 0 when rsp_done pulses.
- R8: A data write has its wait phase after the data byte, a data read before the data byte; in the wait phase the master releases the line and strobes until a strobe is followed by a high sample.
- R9: If WAIT_TRIES wait strobes in a row are followed by low samples, the block pulses rsp_err, sends no stop strobe and returns to the idle line state.
- R10: Every ordinary strobe keeps the clock low for exactly LOW_CYC cycles and then high for at least HIGH_CYC cycles before the next strobe or completion.
- R11: A target reset request holds the clock low for exactly RST_LOW_CYC cycles with the line released, then high for at least RST_POST_CYC cycles before rsp_done.
- R12: Opcodes 5 to 7 complete with rsp_done and produce no clock strobe.
- R13: rsp_done and rsp_err never pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 3 | Request opcode |
| req_data | input | 8 | Address or data byte to send |
| rsp_done | output | 1 | One-cycle pulse on successful completion |
| rsp_err | output | 1 | One-cycle pulse when the wait phase times out |
| rsp_data | output | 8 | Byte sampled by the last read frame |
| busy | output | 1 | A request is in progress |
| tck_o | output | 1 | Link clock |
| tdat_o | output | 1 | Link data output value |
| tdat_oe | output | 1 | Link data output enable |
| tdat_i | input | 1 | Link data input |

## Verification
The bench plays the target: it records the enable and data value at every rising clock edge, measures each low and high phase, and answers wait and read strobes from a prepared response list. Directed frames of each opcode use byte values whose bit patterns expose bit reversal and field swaps, while random requests vary the byte and the number of low wait samples from zero to past the limit. A success on the last allowed try versus a timeout one try later separates an off-by-one in the poll limit, and a request held during a busy frame shows whether the handshake leaks. Reset requests and undefined opcodes check the long low phase and the no-strobe completion.

// File: rtl/dbg2w_pkg.sv
package dbg2w_pkg;

  typedef enum logic [2:0] {
    OP_ADDR_WR = 3'd0,
    OP_ADDR_RD = 3'd1,
    OP_DATA_WR = 3'd2,
    OP_DATA_RD = 3'd3,
    OP_TGT_RST = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    FLD_START,
    FLD_INS,
    FLD_LEN,
    FLD_OUT,
    FLD_WAIT,
    FLD_IN,
    FLD_STOP,
    FLD_RST
  } fld_e;

  // instruction bits, index 0 is sent first
  function automatic logic [1:0] ins_code(input logic [2:0] op);
    case (op)
      OP_ADDR_WR: ins_code = 2'b11;
      OP_ADDR_RD: ins_code = 2'b10;
      OP_DATA_WR: ins_code = 2'b01;
      default:    ins_code = 2'b00;
    endcase
  endfunction

  function automatic logic op_known(input logic [2:0] op);
    op_known = (op <= OP_TGT_RST);
  endfunction

  function automatic logic op_reads(input logic [2:0] op);
    op_reads = (op == OP_ADDR_RD) || (op == OP_DATA_RD);
  endfunction

endpackage

// File: rtl/dbg2w_sync.sv
module dbg2w_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  localparam int N = (STAGES < 1) ? 1 : STAGES;

  logic [N-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[N-1];
endmodule

// File: rtl/dbg2w_strobe.sv
module dbg2w_strobe #(
  parameter int LOW_CYC       = 250,
  parameter int HIGH_CYC      = 250,
  parameter int LONG_LOW_CYC  = 6250,
  parameter int LONG_HIGH_CYC = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic go_i,
  input  logic long_i,
  output logic line_o,
  output logic done_o
);
  localparam int M1   = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
  localparam int M2   = (LONG_LOW_CYC > LONG_HIGH_CYC) ? LONG_LOW_CYC : LONG_HIGH_CYC;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int CW1  = CW + 1;
  localparam logic [CW-1:0] L_M1  = CW'(LOW_CYC - 1);
  localparam logic [CW-1:0] H_M1  = CW'(HIGH_CYC - 1);
  localparam logic [CW-1:0] LL_M1 = CW'(LONG_LOW_CYC - 1);
  localparam logic [CW-1:0] LH_M1 = CW'(LONG_HIGH_CYC - 1);

  typedef enum logic [1:0] {SB_IDLE, SB_LOW, SB_HIGH} sb_e;

  sb_e           st_q;
  logic [CW-1:0] cnt_q;
  logic          long_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SB_IDLE;
      cnt_q  <= '0;
      long_q <= 1'b0;
      line_o <= 1'b1;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        SB_IDLE: begin
          if (go_i) begin
            line_o <= 1'b0;
            long_q <= long_i;
            cnt_q  <= long_i ? LL_M1 : L_M1;
            st_q   <= SB_LOW;
          end
        end
        SB_LOW: begin
          if (cnt_q == '0) begin
            line_o <= 1'b1;
            cnt_q  <= long_q ? LH_M1 : H_M1;
            st_q   <= SB_HIGH;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: begin
          if (cnt_q == '0) begin
            done_o <= 1'b1;
            st_q   <= SB_IDLE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
      endcase
    end
  end

  // independent low-run meter guarding the short-strobe width
  logic [CW1-1:0] lowrun_q;
  always_ff @(posedge clk) begin
    if (rst)          lowrun_q <= '0;
    else if (!line_o) lowrun_q <= lowrun_q + 1'b1;
    else              lowrun_q <= '0;
  end

  assert_short_low_R10: assert property (@(posedge clk) disable iff (rst)
    (!line_o && !long_q) |-> (lowrun_q < CW1'(LOW_CYC)));

  assert_done_high_R10: assert property (@(posedge clk) disable iff (rst)
    done_o |-> line_o);
endmodule

// File: rtl/dbg2w_seq.sv
module dbg2w_seq
  import dbg2w_pkg::*;
#(
  parameter int WAIT_TRIES   = 20,
  parameter int WAIT_GAP_CYC = 250
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [2:0] req_op,
  input  logic [7:0] req_data,
  output logic       busy,
  output logic       rsp_done,
  output logic       rsp_err,
  output logic [7:0] rsp_data,
  output logic       stb_go,
  output logic       stb_long,
  input  logic       stb_done,
  input  logic       din,
  output logic       dat_o,
  output logic       dat_oe
);
  localparam int TW = $clog2(WAIT_TRIES + 1);
  localparam int GW = $clog2(WAIT_GAP_CYC + 1);
  localparam logic [TW-1:0] TRY_LAST = TW'(WAIT_TRIES - 1);
  localparam logic [GW-1:0] GAP_M1   = GW'(WAIT_GAP_CYC - 1);

  typedef enum logic [2:0] {SQ_IDLE, SQ_ISSUE, SQ_STB, SQ_GAP, SQ_FIN} sq_e;

  sq_e           st_q;
  fld_e          fld_q;
  logic [2:0]    op_q;
  logic [7:0]    sh_q;
  logic [2:0]    bit_q;
  logic [TW-1:0] try_q;
  logic [GW-1:0] gap_q;
  logic [1:0]    ins;

  assign ins       = ins_code(op_q);
  assign req_ready = !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= SQ_IDLE;
      fld_q    <= FLD_START;
      op_q     <= 3'd0;
      sh_q     <= 8'd0;
      bit_q    <= 3'd0;
      try_q    <= '0;
      gap_q    <= '0;
      busy     <= 1'b0;
      rsp_done <= 1'b0;
      rsp_err  <= 1'b0;
      rsp_data <= 8'd0;
      stb_go   <= 1'b0;
      stb_long <= 1'b0;
      dat_o    <= 1'b0;
      dat_oe   <= 1'b0;
    end else begin
      stb_go   <= 1'b0;
      rsp_done <= 1'b0;
      rsp_err  <= 1'b0;
      case (st_q)
        SQ_IDLE: begin
          if (req_valid) begin
            op_q  <= req_op;
            sh_q  <= req_data;
            bit_q <= 3'd0;
            try_q <= '0;
            busy  <= 1'b1;
            if (req_op == OP_TGT_RST) begin
              fld_q    <= FLD_RST;
              stb_go   <= 1'b1;
              stb_long <= 1'b1;
              dat_oe   <= 1'b0;
              st_q     <= SQ_STB;
            end else if (!op_known(req_op)) begin
              st_q <= SQ_FIN;
            end else begin
              fld_q <= FLD_START;
              st_q  <= SQ_ISSUE;
            end
          end
        end
        SQ_ISSUE: begin
          stb_long <= 1'b0;
          stb_go   <= 1'b1;
          st_q     <= SQ_STB;
          case (fld_q)
            FLD_INS: begin dat_oe <= 1'b1; dat_o <= ins[bit_q[0]]; end
            FLD_LEN: begin dat_oe <= 1'b1; dat_o <= 1'b0;          end
            FLD_OUT: begin dat_oe <= 1'b1; dat_o <= sh_q[0];       end
            default: begin dat_oe <= 1'b0; dat_o <= 1'b0;          end
          endcase
        end
        SQ_STB: begin
          if (stb_done) begin
            st_q <= SQ_ISSUE;
            case (fld_q)
              FLD_RST: begin
                rsp_done <= 1'b1;
                busy     <= 1'b0;
                st_q     <= SQ_IDLE;
              end
              FLD_START: begin
                fld_q <= FLD_INS;
                bit_q <= 3'd0;
              end
              FLD_INS: begin
                if (bit_q == 3'd1) begin
                  bit_q <= 3'd0;
                  case (op_q)
                    OP_ADDR_WR: fld_q <= FLD_OUT;
                    OP_ADDR_RD: fld_q <= FLD_IN;
                    default:    fld_q <= FLD_LEN;
                  endcase
                end else begin
                  bit_q <= bit_q + 3'd1;
                end
              end
              FLD_LEN: begin
                if (bit_q == 3'd1) begin
                  bit_q <= 3'd0;
                  fld_q <= (op_q == OP_DATA_WR) ? FLD_OUT : FLD_WAIT;
                end else begin
                  bit_q <= bit_q + 3'd1;
                end
              end
              FLD_OUT: begin
                sh_q <= {1'b0, sh_q[7:1]};
                if (bit_q == 3'd7) begin
                  bit_q <= 3'd0;
                  fld_q <= (op_q == OP_ADDR_WR) ? FLD_STOP : FLD_WAIT;
                end else begin
                  bit_q <= bit_q + 3'd1;
                end
              end
              FLD_IN: begin
                sh_q <= {din, sh_q[7:1]};
                if (bit_q == 3'd7) begin
                  bit_q <= 3'd0;
                  fld_q <= FLD_STOP;
                end else begin
                  bit_q <= bit_q + 3'd1;
                end
              end
              FLD_WAIT: begin
                if (din) begin
                  bit_q <= 3'd0;
                  fld_q <= (op_q == OP_DATA_WR) ? FLD_STOP : FLD_IN;
                end else if (try_q == TRY_LAST) begin
                  rsp_err <= 1'b1;
                  busy    <= 1'b0;
                  dat_oe  <= 1'b0;
                  st_q    <= SQ_IDLE;
                end else begin
                  try_q <= try_q + 1'b1;
                  gap_q <= GAP_M1;
                  st_q  <= SQ_GAP;
                end
              end
              default: begin
                if (op_reads(op_q)) rsp_data <= sh_q;
                rsp_done <= 1'b1;
                busy     <= 1'b0;
                st_q     <= SQ_IDLE;
              end
            endcase
          end
        end
        SQ_GAP: begin
          if (gap_q == '0) st_q <= SQ_ISSUE;
          else             gap_q <= gap_q - 1'b1;
        end
        default: begin
          rsp_done <= 1'b1;
          busy     <= 1'b0;
          st_q     <= SQ_IDLE;
        end
      endcase
    end
  end

  assert_excl_R13: assert property (@(posedge clk) disable iff (rst)
    !(rsp_done && rsp_err));

  assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_valid));

  assert_end_R2: assert property (@(posedge clk) disable iff (rst)
    (rsp_done || rsp_err) |-> !busy);

  assert_released_R3: assert property (@(posedge clk) disable iff (rst)
    (st_q == SQ_STB && (fld_q == FLD_START || fld_q == FLD_STOP ||
      fld_q == FLD_WAIT || fld_q == FLD_IN)) |-> !dat_oe);

  assert_timeout_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> ($past(fld_q) == FLD_WAIT) && !dat_oe);
endmodule

// File: rtl/dbg2w_master.sv
module dbg2w_master #(
  parameter int LOW_CYC      = 250,
  parameter int HIGH_CYC     = 250,
  parameter int RST_LOW_CYC  = 6250,
  parameter int RST_POST_CYC = 250,
  parameter int WAIT_GAP_CYC = 250,
  parameter int WAIT_TRIES   = 20,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [2:0] req_op,
  input  logic [7:0] req_data,
  output logic       rsp_done,
  output logic       rsp_err,
  output logic [7:0] rsp_data,
  output logic       busy,
  output logic       tck_o,
  output logic       tdat_o,
  output logic       tdat_oe,
  input  logic       tdat_i
);
  logic stb_go, stb_long, stb_done, din_s;

  dbg2w_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (tdat_i),
    .q_o (din_s)
  );

  dbg2w_strobe #(
    .LOW_CYC      (LOW_CYC),
    .HIGH_CYC     (HIGH_CYC),
    .LONG_LOW_CYC (RST_LOW_CYC),
    .LONG_HIGH_CYC(RST_POST_CYC)
  ) u_strobe (
    .clk    (clk),
    .rst    (rst),
    .go_i   (stb_go),
    .long_i (stb_long),
    .line_o (tck_o),
    .done_o (stb_done)
  );

  dbg2w_seq #(
    .WAIT_TRIES  (WAIT_TRIES),
    .WAIT_GAP_CYC(WAIT_GAP_CYC)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_op   (req_op),
    .req_data (req_data),
    .busy     (busy),
    .rsp_done (rsp_done),
    .rsp_err  (rsp_err),
    .rsp_data (rsp_data),
    .stb_go   (stb_go),
    .stb_long (stb_long),
    .stb_done (stb_done),
    .din      (din_s),
    .dat_o    (tdat_o),
    .dat_oe   (tdat_oe)
  );

  assert_idle_lines_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (tck_o && !tdat_oe));
endmodule

// File: tb/test_dbg2w_master.sv
module test_dbg2w_master;
  localparam int LOWC  = 3;
  localparam int HIGHC = 2;
  localparam int RLOW  = 12;
  localparam int RPOST = 3;
  localparam int GAPC  = 2;
  localparam int TRIES = 20;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, req_valid, req_ready, rsp_done, rsp_err, busy;
  logic tck_o, tdat_o, tdat_oe, tdat_i;
  logic [2:0] req_op;
  logic [7:0] req_data, rsp_data;

  dbg2w_master #(
    .LOW_CYC(LOWC), .HIGH_CYC(HIGHC), .RST_LOW_CYC(RLOW), .RST_POST_CYC(RPOST),
    .WAIT_GAP_CYC(GAPC), .WAIT_TRIES(TRIES), .SYNC_STAGES(2)
  ) i_dbg2w_master (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_data(req_data), .rsp_done(rsp_done), .rsp_err(rsp_err),
    .rsp_data(rsp_data), .busy(busy), .tck_o(tck_o), .tdat_o(tdat_o),
    .tdat_oe(tdat_oe), .tdat_i(tdat_i)
  );

  int n_chk = 0;
  int n_bad = 0;

  logic rec_oe [64];
  logic rec_dat[64];
  int   rec_low[64];
  logic resp   [64];
  logic exp_oe [64];
  logic exp_dat[64];
  int   exp_n, nstb, lowrun, highrun, min_high;
  logic exp_err;
  logic prev_tck = 1'b1;

  // target model: records each strobe, answers from resp[]
  always @(negedge clk) begin
    if (prev_tck && !tck_o) begin
      lowrun = 1;
      if (nstb > 0 && highrun < min_high) min_high = highrun;
      if (nstb < 64) tdat_i = resp[nstb];
    end else if (!tck_o) begin
      lowrun++;
    end
    if (!prev_tck && tck_o) begin
      if (nstb < 64) begin
        rec_oe[nstb]  = tdat_oe;
        rec_dat[nstb] = tdat_o;
        rec_low[nstb] = lowrun;
      end
      nstb++;
      highrun = 0;
    end else if (tck_o) begin
      highrun++;
    end
    prev_tck = tck_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic push(input logic oe, input logic d);
    exp_oe[exp_n]  = oe;
    exp_dat[exp_n] = d;
    exp_n++;
  endtask

  task automatic add_wait(input int nwait);
    for (int i = 0; i < nwait && i < TRIES; i++) begin
      resp[exp_n] = 1'b0;
      push(1'b0, 1'b0);
    end
    if (nwait < TRIES) begin
      resp[exp_n] = 1'b1;
      push(1'b0, 1'b0);
    end else begin
      exp_err = 1'b1;
    end
  endtask

  // expected frame computed from the requirements
  task automatic build(input logic [2:0] op, input logic [7:0] d, input int nwait,
                       input logic [7:0] rd);
    exp_n = 0;
    exp_err = 1'b0;
    for (int i = 0; i < 64; i++) resp[i] = 1'b0;
    case (op)
      3'd0: begin
        push(0, 0); push(1, 1); push(1, 1);
        for (int i = 0; i < 8; i++) push(1, d[i]);
        push(0, 0);
      end
      3'd1: begin
        push(0, 0); push(1, 0); push(1, 1);
        for (int i = 0; i < 8; i++) begin resp[exp_n] = rd[i]; push(0, 0); end
        push(0, 0);
      end
      3'd2: begin
        push(0, 0); push(1, 1); push(1, 0); push(1, 0); push(1, 0);
        for (int i = 0; i < 8; i++) push(1, d[i]);
        add_wait(nwait);
        if (!exp_err) push(0, 0);
      end
      3'd3: begin
        push(0, 0); push(1, 0); push(1, 0); push(1, 0); push(1, 0);
        add_wait(nwait);
        if (!exp_err) begin
          for (int i = 0; i < 8; i++) begin resp[exp_n] = rd[i]; push(0, 0); end
          push(0, 0);
        end
      end
      3'd4: push(0, 0);
      default: ;
    endcase
  endtask

  task automatic run(input logic [2:0] op, input logic [7:0] d, input int nwait,
                     input logic [7:0] rd, input bit intrude);
    int cyc, bad_bits, bad_low, lim, nck;
    build(op, d, nwait, rd);
    nstb = 0;
    min_high = 1000;
    @(negedge clk);
    req_valid = 1'b1;
    req_op    = op;
    req_data  = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy === 1'b1 && req_ready === 1'b0, "R2 busy after accept", busy, 1);
    if (intrude) begin
      repeat (4) @(negedge clk);
      req_valid = 1'b1;
      req_op    = 3'd2;
      req_data  = 8'hFF;
      repeat (10) @(negedge clk);
      req_valid = 1'b0;
    end
    cyc = 0;
    while (!(rsp_done || rsp_err) && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    chk(!(rsp_done && rsp_err), "R13 done and err together", int'(rsp_err), 0);
    chk(rsp_err === exp_err, exp_err ? "R9 timeout error" : "R9 no error", int'(rsp_err), int'(exp_err));
    chk(busy === 1'b0, "R2 busy at completion", int'(busy), 0);
    if (op > 3'd4) chk(nstb == 0, "R12 no strobe for undefined opcode", nstb, 0);
    else           chk(nstb == exp_n, "R3 strobe count", nstb, exp_n);
    nck = (nstb < exp_n) ? nstb : exp_n;
    if (nck > 64) nck = 64;
    if (exp_n > 0) begin
      chk(rec_oe[0] == 1'b0, "R3 start strobe released", int'(rec_oe[0]), 0);
      if (!exp_err && nstb > 0 && nstb <= 64)
        chk(rec_oe[nstb-1] == 1'b0, "R3 stop strobe released", int'(rec_oe[nstb-1]), 0);
    end
    if (op <= 3'd3 && nck >= 3)
      chk(rec_oe[1] && rec_oe[2] && rec_dat[1] == exp_dat[1] && rec_dat[2] == exp_dat[2],
          "R4 instruction bits", {rec_dat[2], rec_dat[1]}, {exp_dat[2], exp_dat[1]});
    bad_bits = 0;
    bad_low  = 0;
    lim = (op == 3'd4) ? RLOW : LOWC;
    for (int i = 0; i < nck; i++) begin
      if (rec_oe[i] !== exp_oe[i] || (exp_oe[i] && rec_dat[i] !== exp_dat[i])) bad_bits++;
      if (rec_low[i] != lim) bad_low++;
    end
    if (op == 3'd0 || op == 3'd2)
      chk(bad_bits == 0, "R6 sent bits (R5 length, R8 wait)", bad_bits, 0);
    else if (op == 3'd1 || op == 3'd3)
      chk(bad_bits == 0, "R7 read frame fields (R5 length, R8 wait)", bad_bits, 0);
    if (op == 3'd4) begin
      chk(bad_low == 0 && nck == 1, "R11 reset low width", nck > 0 ? rec_low[0] : 0, RLOW);
      chk(highrun >= RPOST, "R11 hold after reset", highrun, RPOST);
    end else if (op < 3'd4) begin
      chk(bad_low == 0, "R10 strobe low width", bad_low, 0);
      chk(min_high >= HIGHC, "R10 high between strobes", min_high, HIGHC);
    end
    if ((op == 3'd1 || op == 3'd3) && !exp_err)
      chk(rsp_data === rd, "R7 read byte", rsp_data, rd);
    @(negedge clk);
    chk(tck_o === 1'b1 && tdat_oe === 1'b0 && req_ready === 1'b1, "R1 idle lines",
        {tck_o, tdat_oe, req_ready}, 3'b101);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired R2 actual=0 expected=1");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [2:0] op;
    int nw, sel, dummy;
    dummy = $urandom(32'd20240611);
    rst = 1'b1;
    req_valid = 1'b0;
    req_op = 3'd0;
    req_data = 8'd0;
    tdat_i = 1'b0;
    nstb = 0;
    highrun = 0;
    lowrun = 0;
    min_high = 1000;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(tck_o === 1'b1 && tdat_oe === 1'b0 && req_ready === 1'b1 && busy === 1'b0,
        "R1 reset state", {tck_o, tdat_oe, req_ready, busy}, 4'b1010);

    run(3'd0, 8'hA5, 0, 8'h00, 1'b0);
    run(3'd0, 8'h01, 0, 8'h00, 1'b0);
    run(3'd1, 8'h00, 0, 8'h3C, 1'b0);
    run(3'd1, 8'h00, 0, 8'h80, 1'b0);
    run(3'd2, 8'h81, 0, 8'h00, 1'b0);
    run(3'd3, 8'h00, 0, 8'hC6, 1'b0);
    run(3'd2, 8'h5A, TRIES - 1, 8'h00, 1'b0);
    run(3'd3, 8'h00, TRIES - 1, 8'h0F, 1'b0);
    run(3'd3, 8'h00, TRIES, 8'h00, 1'b0);
    run(3'd2, 8'h77, TRIES, 8'h00, 1'b0);
    run(3'd4, 8'h00, 0, 8'h00, 1'b0);
    run(3'd5, 8'h00, 0, 8'h00, 1'b0);
    run(3'd7, 8'h00, 0, 8'h00, 1'b0);
    run(3'd0, 8'hC3, 0, 8'h00, 1'b1);
    run(3'd3, 8'h00, 2, 8'h96, 1'b1);

    for (int k = 0; k < 150; k++) begin
      op  = 3'($urandom_range(0, 5));
      sel = $urandom_range(0, 9);
      if (sel == 0)      nw = TRIES - 1;
      else if (sel == 1) nw = TRIES;
      else               nw = $urandom_range(0, 5);
      run(op, 8'($urandom), nw, 8'($urandom), 1'b0);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule